// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host processor reach the 16-bit management registers of Ethernet PHYs over the two-wire MDC/MDIO bus. The host talks to a small word-addressed register file. It sets an MDC divider code, loads a PHY address and register number, and then starts a frame. Writing the data register launches a write frame. Writing the command register with its read bit set launches a read frame. The host polls a busy register until the frame has finished, and after a read it collects the returned value from a status register.

The controller derives MDC from its own clock and sends Clause 22 frames most significant bit first, in this order: preamble, start, opcode, PHY address, register number, turnaround, data. In a write frame it drives MDIO for the whole frame. In a read frame it releases the line from the turnaround onwards and shifts in the PHY's answer. The MDIO pin is split into an output, an output enable and an input, so the pad can be placed outside this block. A soft-reset bit in the configuration register stops any frame in progress and holds the controller idle for as long as it stays set.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads zero (offsets 0 to 5), MDC is low and the MDIO output enable is low.
- R2: The address register (offset 2) keeps the register number in bits 4:0 and the PHY address in bits 12:8. All other bits read back as zero, and both fields go into the frame that is sent next.
- R3: A write to the data register (offset 3) while the controller is idle stores bits 15:0 and starts a write frame. Busy reads 1 from the cycle after that write and stays 1 for exactly 64 MDC periods.
- R4: A write frame sends, most significant bit first: 32 ones, start 01, opcode 01, 5-bit PHY address, 5-bit register number, turnaround 10 and 16 data bits. The output enable stays high for the whole frame, and the MDIO output changes only in the cycle in which MDC falls.
- R5: Writing 1 to bit 0 of the command register (offset 1) while idle starts a read frame with opcode 10. The output enable is high for frame bits 0 to 45 and low for the turnaround and data bits 46 to 63. MDIO is sampled at each rising MDC edge of the data bits, and the 16-bit result appears in bits 15:0 of the status register (offset 4) once busy clears.
- R6: Configuration register (offset 0) bits 2:0 select the MDC divider: code 0 divides the clock by 4, code 3 by 8, code 6 by 20, and any other code by 8. MDC is a square wave with a half period of divider/2 clocks, and it stays low between frames.
- R7: Writes to the command or data register while busy reads 1 are ignored. The frame in progress is not disturbed, no new frame follows, and both registers keep their values.
- R8: Writing configuration bit 31 as 1 aborts any frame at once: busy goes to 0, MDC goes low, the output enable goes low and status is cleared. While the bit stays 1, command and data writes are ignored. Writing it back to 0 lets frames start again.
- R9: The busy register (offset 5) reads 1 in bit 0 while a frame is in progress and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the MDC reference |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | BUS_W | Register write data |
| reg_rdata | output | BUS_W | Read data of the register at reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable, high to drive |
| mdio_in | input | 1 | MDIO value seen at the pad |

## Verification
The bench goes after the edges of a frame. It checks that busy rises one cycle after the trigger and drops exactly at the last falling MDC edge. A design off by one there would show a busy count other than 64 MDC periods, or MDC would be left high. It also checks that the turnaround is released at bit 46 and not at bit 48, since a design that is late there would drive against the PHY. Command and data writes made in the middle of a frame must not restart it or change the stored data. It runs every divider code, including an unlisted one, so a wrong table entry shows up as a wrong MDC period. Finally, it applies soft reset in the middle of a frame, so a design that finishes the frame anyway, leaves MDC high or keeps the old status would be caught.

// File: rtl/mdio_pkg.sv
// Shared constants for the MDIO management master: frame layout,
// register offsets and the divider code table.
// Assumes Clause 22 frames only.
package mdio_pkg;
    localparam int PRE_LEN   = 32;
    localparam int ADDR_LEN  = 5;
    localparam int DATA_LEN  = 16;
    localparam int TA_IDX    = PRE_LEN + 2 + 2 + 2 * ADDR_LEN;
    localparam int DATA_IDX  = TA_IDX + 2;
    localparam int FRAME_LEN = DATA_IDX + DATA_LEN;
    localparam int HALF_W    = 5;

    localparam logic [2:0] OFF_CFG    = 3'd0;
    localparam logic [2:0] OFF_CMD    = 3'd1;
    localparam logic [2:0] OFF_ADDR   = 3'd2;
    localparam logic [2:0] OFF_DATA   = 3'd3;
    localparam logic [2:0] OFF_STATUS = 3'd4;
    localparam logic [2:0] OFF_BUSY   = 3'd5;

    // Half MDC period in system clocks for a divider code.
    function automatic logic [HALF_W-1:0] half_from_code(input logic [2:0] code);
        case (code)
            3'd0:    half_from_code = HALF_W'(2);
            3'd6:    half_from_code = HALF_W'(10);
            default: half_from_code = HALF_W'(4);
        endcase
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
// MDC generator: while enabled, toggles mdc every `half` clocks and flags the
// cycle in which it rises or falls. Assumes half >= 2 and is held during a frame.
module mdio_clkgen #(
    parameter int HALF_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [HALF_W-1:0] half,
    output logic              mdc,
    output logic              rise_tick,
    output logic              fall_tick
);
    logic [HALF_W-1:0] cnt;
    logic              edge_now;

    assign edge_now  = en && (cnt == half - 1'b1);
    assign rise_tick = edge_now && !mdc;
    assign fall_tick = edge_now && mdc;

    // Count clocks within a half period and toggle mdc at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (edge_now) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc);
endmodule

// File: rtl/mdio_frame.sv
// Frame sequencer: loads a 64-bit Clause 22 frame on start, shifts one bit per
// falling MDC tick, releases MDIO from the turnaround of a read and samples
// read data on rising ticks. Assumes starts arrive only while idle.
module mdio_frame
    import mdio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                abort,
    input  logic                start_wr,
    input  logic                start_rd,
    input  logic [ADDR_LEN-1:0] phy,
    input  logic [ADDR_LEN-1:0] regn,
    input  logic [DATA_LEN-1:0] wdata,
    input  logic                rise_tick,
    input  logic                fall_tick,
    input  logic                mdio_in,
    output logic                busy,
    output logic                mdio_out,
    output logic                mdio_oe,
    output logic                rd_done,
    output logic [DATA_LEN-1:0] rd_data
);
    localparam int IDX_W = $clog2(FRAME_LEN);

    logic [FRAME_LEN-1:0] shift_q;
    logic [FRAME_LEN-1:0] frame_w;
    logic [IDX_W-1:0]     bit_idx;
    logic                 is_read;
    logic                 last_bit;

    assign frame_w  = {{PRE_LEN{1'b1}}, 2'b01, (start_rd ? 2'b10 : 2'b01),
                       phy, regn, 2'b10, (start_rd ? {DATA_LEN{1'b0}} : wdata)};
    assign last_bit = (bit_idx == IDX_W'(FRAME_LEN - 1));
    assign mdio_out = shift_q[FRAME_LEN-1];
    assign mdio_oe  = busy && (!is_read || bit_idx < IDX_W'(TA_IDX));
    assign rd_done  = busy && is_read && fall_tick && last_bit;

    // Frame state: load on start, advance on falling tick, stop after last bit.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy    <= 1'b0;
            is_read <= 1'b0;
            bit_idx <= '0;
            shift_q <= '0;
        end else if (!busy && (start_wr || start_rd)) begin
            busy    <= 1'b1;
            is_read <= start_rd;
            bit_idx <= '0;
            shift_q <= frame_w;
        end else if (busy && fall_tick) begin
            if (last_bit) begin
                busy <= 1'b0;
            end
            bit_idx <= bit_idx + 1'b1;
            shift_q <= {shift_q[FRAME_LEN-2:0], 1'b1};
        end
    end

    // Capture read data on rising MDC during the data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (busy && is_read && rise_tick && bit_idx >= IDX_W'(DATA_IDX)) begin
            rd_data <= {rd_data[DATA_LEN-2:0], mdio_in};
        end
    end

    // R4
    mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fall_tick && !abort) |=> $stable(mdio_out));

    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(fall_tick || abort));
endmodule

// File: rtl/mdio_master.sv
// Register-mapped MDIO management master: register file, start and ignore
// rules, soft reset, and the wiring of MDC generation and frame sequencing.
// Assumes BUS_W >= 32 and one register write per cycle.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    output logic             mdc,
    output logic             mdio_out,
    output logic             mdio_oe,
    input  logic             mdio_in
);
    localparam int SRST_BIT = BUS_W - 1;

    logic [2:0]          cfg_code;
    logic                srst_q;
    logic                cmd_q;
    logic [ADDR_LEN-1:0] phy_q;
    logic [ADDR_LEN-1:0] regn_q;
    logic [DATA_LEN-1:0] data_q;
    logic [DATA_LEN-1:0] status_q;
    logic [HALF_W-1:0]   half_q;
    logic                busy, rise_tick, fall_tick, rd_done;
    logic [DATA_LEN-1:0] rd_data;
    logic                wr_cfg, wr_cmd, wr_addr, wr_data;
    logic                abort, can_start, start_wr, start_rd;

    assign wr_cfg    = reg_wr && (reg_addr == OFF_CFG);
    assign wr_cmd    = reg_wr && (reg_addr == OFF_CMD);
    assign wr_addr   = reg_wr && (reg_addr == OFF_ADDR);
    assign wr_data   = reg_wr && (reg_addr == OFF_DATA);
    assign abort     = srst_q || (wr_cfg && reg_wdata[SRST_BIT]);
    assign can_start = !busy && !srst_q;
    assign start_wr  = wr_data && can_start;
    assign start_rd  = wr_cmd && can_start && reg_wdata[0];

    // Register file updates, honouring busy and soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_code <= '0;
            srst_q   <= 1'b0;
            cmd_q    <= 1'b0;
            phy_q    <= '0;
            regn_q   <= '0;
            data_q   <= '0;
            status_q <= '0;
            half_q   <= half_from_code(3'd0);
        end else begin
            if (wr_cfg) begin
                cfg_code <= reg_wdata[2:0];
                srst_q   <= reg_wdata[SRST_BIT];
            end
            if (wr_addr) begin
                phy_q  <= reg_wdata[8 +: ADDR_LEN];
                regn_q <= reg_wdata[0 +: ADDR_LEN];
            end
            if (wr_cmd && can_start) begin
                cmd_q <= reg_wdata[0];
            end
            if (start_wr) begin
                data_q <= reg_wdata[DATA_LEN-1:0];
            end
            if (start_wr || start_rd) begin
                half_q <= half_from_code(cfg_code);
            end
            if (abort) begin
                status_q <= '0;
            end else if (rd_done) begin
                status_q <= rd_data;
            end
        end
    end

    // Read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CFG: begin
                reg_rdata[2:0]      = cfg_code;
                reg_rdata[SRST_BIT] = srst_q;
            end
            OFF_CMD:    reg_rdata[0] = cmd_q;
            OFF_ADDR: begin
                reg_rdata[8 +: ADDR_LEN] = phy_q;
                reg_rdata[0 +: ADDR_LEN] = regn_q;
            end
            OFF_DATA:   reg_rdata[DATA_LEN-1:0] = data_q;
            OFF_STATUS: reg_rdata[DATA_LEN-1:0] = status_q;
            OFF_BUSY:   reg_rdata[0] = busy;
            default:    reg_rdata = '0;
        endcase
    end

    mdio_clkgen #(.HALF_W(HALF_W)) i_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (busy && !abort),
        .half      (half_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (abort),
        .start_wr  (start_wr),
        .start_rd  (start_rd),
        .phy       (phy_q),
        .regn      (regn_q),
        .wdata     (reg_wdata[DATA_LEN-1:0]),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_in),
        .busy      (busy),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .rd_done   (rd_done),
        .rd_data   (rd_data)
    );

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_q));

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(data_q));

    // R8
    srst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |-> (!busy && !mdc && !mdio_oe));

    // R9
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr));
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd5;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    always #5 clk = ~clk;

    mdio_master i_mdio_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .mdio_in   (mdio_in)
    );

    int checks = 0;
    int errors = 0;

    // Behavioural reference state.
    bit          m_busy = 0, m_rd = 0, m_srst = 0;
    int          m_n = 0, m_h = 2, m_code = 0;
    logic [4:0]  m_phy = '0, m_reg = '0;
    logic [63:0] m_f = '0;
    logic [15:0] phy_val = '0;

    function automatic int half_of(input int code);
        if (code == 0) return 2;
        if (code == 6) return 10;
        return 4;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model advanced on every rising edge.
    always @(posedge clk) begin
        bit b0, s0;
        b0 = m_busy;
        s0 = m_srst;
        if (!rst_n) begin
            m_busy = 0; m_rd = 0; m_srst = 0; m_code = 0; m_n = 0;
            m_phy = '0; m_reg = '0;
        end else begin
            if (m_busy) begin
                m_n++;
                if (m_n == 128 * m_h) m_busy = 0;
            end
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: begin
                        m_code = int'(reg_wdata[2:0]);
                        m_srst = reg_wdata[31];
                        if (reg_wdata[31]) m_busy = 0;
                    end
                    3'd2: begin
                        m_phy = reg_wdata[12:8];
                        m_reg = reg_wdata[4:0];
                    end
                    3'd3: if (!b0 && !s0) begin
                        m_busy = 1; m_n = 0; m_rd = 0; m_h = half_of(m_code);
                        m_f = {32'hFFFF_FFFF, 2'b01, 2'b01, m_phy, m_reg, 2'b10, reg_wdata[15:0]};
                    end
                    3'd1: if (!b0 && !s0 && reg_wdata[0]) begin
                        m_busy = 1; m_n = 0; m_rd = 1; m_h = half_of(m_code);
                        m_f = {32'hFFFF_FFFF, 2'b01, 2'b10, m_phy, m_reg, 18'h0};
                    end
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison and PHY response, away from the clock edge.
    always begin
        int bi;
        bit e_mdc, e_oe;
        @(negedge clk);
        #2;
        bi = m_busy ? m_n / (2 * m_h) : 0;
        e_mdc = m_busy && (((m_n / m_h) % 2) == 1);
        e_oe = m_busy && (!m_rd || bi < 46);
        if (rst_n) begin
            chk("R6", "mdc", {31'b0, mdc}, {31'b0, e_mdc});
            chk(m_rd ? "R5" : "R4", "mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
            if (e_oe) chk("R4", "mdio_out", {31'b0, mdio_out}, {31'b0, m_f[63 - bi]});
            if (reg_addr == 3'd5) chk("R9", "busy", reg_rdata, {31'b0, m_busy});
        end
        if (m_busy && m_rd && bi >= 48) mdio_in = phy_val[15 - (bi - 48)];
        else mdio_in = 1'b1;
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd5; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, "register read", reg_rdata, exp);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (m_busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    // Count cycles busy reads 1, starting right after the triggering write.
    task automatic frame_len(input int exp, input string req);
        int c = 0;
        #3;
        while (reg_rdata[0] && c < 5000) begin
            c++;
            @(negedge clk);
            #3;
        end
        chk(req, "busy length", c, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 6; a++) rd(3'(a), 32'h0, "R1");
        chk("R1", "mdc at reset", {31'b0, mdc}, 32'h0);
        chk("R1", "oe at reset", {31'b0, mdio_oe}, 32'h0);
        // R2 address layout
        wr(3'd2, 32'hABCD_F5EA);
        rd(3'd2, 32'h0000_150A, "R2");
        // R3 write frame, divide by 4
        wr(3'd3, 32'h5555_1234);
        frame_len(256, "R3");
        rd(3'd3, 32'h0000_1234, "R3");
        rd(3'd4, 32'h0, "R4");
        // R7 writes during busy ignored
        wr(3'd3, 32'h0000_C0DE);
        repeat (20) @(negedge clk);
        wr(3'd3, 32'h0000_FFFF);
        wr(3'd1, 32'h1);
        wait_idle();
        rd(3'd3, 32'h0000_C0DE, "R7");
        rd(3'd1, 32'h0, "R7");
        rd(3'd5, 32'h0, "R7");
        // R5 read frame, divide by 8
        wr(3'd0, 32'h3);
        phy_val = 16'hBEEF;
        wr(3'd1, 32'h1);
        frame_len(512, "R6");
        rd(3'd4, 32'h0000_BEEF, "R5");
        rd(3'd1, 32'h1, "R5");
        wr(3'd1, 32'h0);
        rd(3'd1, 32'h0, "R5");
        // R6 divide by 20 with a read
        wr(3'd0, 32'h6);
        wr(3'd2, 32'h0000_031F);
        phy_val = 16'h5A3C;
        wr(3'd1, 32'h1);
        frame_len(1280, "R6");
        rd(3'd4, 32'h0000_5A3C, "R5");
        wr(3'd1, 32'h0);
        // R6 unlisted code falls back to divide by 8
        wr(3'd0, 32'h5);
        wr(3'd3, 32'h0000_8001);
        frame_len(512, "R6");
        // R8 soft reset mid-frame
        wr(3'd0, 32'h0);
        wr(3'd3, 32'h0000_0F0F);
        repeat (40) @(negedge clk);
        wr(3'd0, 32'h8000_0000);
        #3;
        chk("R8", "mdc after abort", {31'b0, mdc}, 32'h0);
        chk("R8", "oe after abort", {31'b0, mdio_oe}, 32'h0);
        rd(3'd5, 32'h0, "R8");
        rd(3'd4, 32'h0, "R8");
        wr(3'd3, 32'h0000_7777);
        rd(3'd5, 32'h0, "R8");
        rd(3'd3, 32'h0000_0F0F, "R8");
        wr(3'd1, 32'h1);
        rd(3'd1, 32'h0, "R8");
        wr(3'd0, 32'h0);
        wr(3'd3, 32'h0000_00FF);
        frame_len(256, "R8");
        rd(3'd3, 32'h0000_00FF, "R8");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired before the run ended");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule